// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table held in memory. Pages are 4 KB. A walk starts from a root table address supplied with the request. The top ten bits of the virtual address select a 4-byte entry in the root table, and that entry names a second-level table. The next ten bits select an entry in that table, and that entry names the physical page frame. The low twelve bits of the virtual address pass through unchanged as the page offset.

The two table reads depend on each other, so they are issued one at a time through a single read request/response port to memory. An entry whose valid bit is clear ends the walk with a page fault, and the fault records whether it occurred at the first level or the second. Only one walk is in progress at a time. The result stays on the outputs until the requester acknowledges it, and the walker then returns to idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, res_valid is 0 and mem_rd_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only while no walk is running and no result is being held.
- R3: The first read goes to address {req_root[31:2],2'b00} + 4*vaddr[31:22]. The two low bits of the root are ignored.
- R4: When the first entry is valid, the second read goes to {entry1[31:12], vaddr[21:12], 2'b00}. Bits [11:1] of the entry are ignored.
- R5: When both entries are valid, the result has res_paddr = {entry2[31:12], vaddr[11:0]}, res_fault = 0 and res_fault_level = 0.
- R6: When the first entry has bit 0 clear, no second read is issued. The result has res_fault = 1, res_fault_level = 1 and res_paddr = 0.
- R7: When the second entry has bit 0 clear, the result has res_fault = 1, res_fault_level = 2 and res_paddr = 0.
- R8: A read request keeps mem_rd_valid and mem_rd_addr steady until mem_rd_ready is 1. Each walk issues exactly one read per level that it reaches, whatever the response latency.
- R9: res_valid and the result fields hold steady until the cycle in which res_ack is 1. On the edge after that cycle the walker is idle again (req_ready = 1).
- R10: A request presented while a walk is running or a result is being held is ignored. It has no effect on the result of the walk already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A walk request is offered |
| req_ready | output | 1 | The walker is idle and can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the root table |
| mem_rd_valid | output | 1 | A table read is requested |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | The read data is present |
| mem_rsp_data | input | 32 | Table entry: bit 0 valid, bits [31:12] base |
| res_valid | output | 1 | The walk result is present |
| res_paddr | output | 32 | Physical address, or 0 on a fault |
| res_fault | output | 1 | The walk ended in a page fault |
| res_fault_level | output | 2 | 0 for no fault, 1 for a first-level fault, 2 for a second-level fault |
| res_ack | input | 1 | The requester takes the result |

## Verification
The hardest case to reach from the ports is a new request arriving while the walker is busy, at the same time as memory stalls both its request acceptance and its responses. The bench reaches it by keeping req_valid asserted with a different address for the whole of a walk. Meanwhile the memory model refuses the request handshake on a fixed cycle pattern and delays each response by a latency chosen per walk. Every read address is compared against an expected sequence, so a read that is repeated, skipped or issued after a first-level fault is caught. Results are also held unacknowledged for several cycles to check that they stay stable.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [IDX_W+2+2*IDX_W-1:0]        req_vaddr,
  input  logic [IDX_W+2+2*IDX_W-1:0]        req_root,
  output logic                              mem_rd_valid,
  input  logic                              mem_rd_ready,
  output logic [IDX_W+2+2*IDX_W-1:0]        mem_rd_addr,
  input  logic                              mem_rsp_valid,
  input  logic [IDX_W+2+2*IDX_W-1:0]        mem_rsp_data,
  output logic                              res_valid,
  output logic [IDX_W+2+2*IDX_W-1:0]        res_paddr,
  output logic                              res_fault,
  output logic [1:0]                        res_fault_level,
  input  logic                              res_ack
);
  localparam int OFF_W = IDX_W + 2;
  localparam int AW    = OFF_W + 2 * IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_DONE} st_t;

  st_t             st;
  logic            pend;
  logic [AW-1:0]   va_q, base_q, pa_q;
  logic [1:0]      lvl_q;

  wire [IDX_W-1:0] i1 = va_q[AW-1 -: IDX_W];
  wire [IDX_W-1:0] i2 = va_q[OFF_W +: IDX_W];
  wire walking  = (st == S_L1) || (st == S_L2);
  wire rsp_take = walking && pend && mem_rsp_valid;

  wire [AW-1:0] l1_addr = {base_q[AW-1:2], 2'b00} + {{(AW-IDX_W-2){1'b0}}, i1, 2'b00};
  wire [AW-1:0] l2_addr = {base_q[AW-1:OFF_W], i2, 2'b00};

  assign req_ready       = (st == S_IDLE);
  assign mem_rd_valid    = walking && !pend;
  assign mem_rd_addr     = (st == S_L1) ? l1_addr : l2_addr;
  assign res_valid       = (st == S_DONE);
  assign res_paddr       = pa_q;
  assign res_fault       = (lvl_q != 2'd0);
  assign res_fault_level = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= 1'b0;
      va_q   <= '0;
      base_q <= '0;
      pa_q   <= '0;
      lvl_q  <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= req_root;
          pa_q   <= '0;
          lvl_q  <= 2'd0;
          st     <= S_L1;
        end
        S_L1, S_L2: begin
          if (mem_rd_valid && mem_rd_ready) pend <= 1'b1;
          if (rsp_take) begin
            pend <= 1'b0;
            if (!mem_rsp_data[0]) begin
              lvl_q <= (st == S_L1) ? 2'd1 : 2'd2;
              st    <= S_DONE;
            end else if (st == S_L1) begin
              base_q <= mem_rsp_data;
              st     <= S_L2;
            end else begin
              pa_q <= {mem_rsp_data[AW-1:OFF_W], va_q[OFF_W-1:0]};
              st   <= S_DONE;
            end
          end
        end
        S_DONE: if (res_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          res_valid,
  input logic [AW-1:0] res_paddr,
  input logic          res_fault,
  input logic [1:0]    res_fault_level,
  input logic          res_ack
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || res_valid) |-> !req_ready); // R2
  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !res_valid)); // R10
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00)); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_paddr) && $stable(res_fault_level))); // R9
  AST_ACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ack) |=> req_ready); // R9
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_paddr == '0)); // R6
endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0, req_root = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic [1:0]  res_fault_level;
  logic        res_ack = 1'b0;

  always #4 clk = ~clk;

  pt_walker u0 (.*);

  typedef struct { logic [31:0] pa; logic [1:0] lvl; int ackdly; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  int unsigned pt[int unsigned];
  int errors = 0, checks = 0, done_cnt = 0, cyc = 0, rsp_lat = 1, rsp_cnt = 0;
  logic [31:0] rsp_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pt.exists(a) ? pt[a] : 32'h0;
  endfunction

  always @(posedge clk) cyc++;

  // memory model: request stalls on a pattern, response after rsp_lat cycles
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    mem_rd_ready = (cyc % 3 != 1);
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(rsp_addr);
      end
    end
    if (rst_n && mem_rd_valid && mem_rd_ready) begin
      if (addr_q.size() == 0) chk(0, "R8 unexpected read", mem_rd_addr, 32'h0);
      else begin
        logic [31:0] e;
        e = addr_q.pop_front();
        chk(mem_rd_addr == e, "R3/R4 read address", mem_rd_addr, e);
      end
      rsp_addr = mem_rd_addr;
      rsp_cnt  = rsp_lat;
    end
  end

  // monitor / scoreboard
  int hold = 0;
  bit seen = 0;
  logic [31:0] snap_pa;
  always @(negedge clk) begin
    if (res_ack) res_ack = 1'b0;
    else if (rst_n && res_valid) begin
      if (!seen) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected result", res_paddr, 32'h0);
          e.pa = '0; e.lvl = '0; e.ackdly = 0;
        end else e = exp_q.pop_front();
        chk(res_paddr == e.pa, "R5/R6/R7 paddr", res_paddr, e.pa);
        chk(res_fault_level == e.lvl, "R5/R6/R7 fault level", {30'b0, res_fault_level}, {30'b0, e.lvl});
        chk(res_fault == (e.lvl != 0), "R6/R7 fault flag", {31'b0, res_fault}, {31'b0, e.lvl != 0});
        chk(addr_q.size() == 0, "R8 reads per walk", addr_q.size(), 0);
        snap_pa = res_paddr;
        hold = e.ackdly;
        seen = 1;
      end else chk(res_paddr == snap_pa, "R9 result held", res_paddr, snap_pa);
      if (hold == 0) begin
        res_ack = 1'b1;
        seen = 0;
        done_cnt++;
      end else hold--;
    end else if (rst_n && seen) chk(0, "R9 result dropped", {31'b0, res_valid}, 32'h1);
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] root, input int lat,
                      input int ackdly, input bit spam);
    exp_t e;
    logic [31:0] a1, e1, a2, e2;
    int n;
    a1 = {root[31:2], 2'b00} + {20'b0, va[31:22], 2'b00};
    e1 = rd(a1);
    addr_q.push_back(a1);
    if (!e1[0]) begin e.pa = '0; e.lvl = 2'd1; end
    else begin
      a2 = {e1[31:12], va[21:12], 2'b00};
      e2 = rd(a2);
      addr_q.push_back(a2);
      if (!e2[0]) begin e.pa = '0; e.lvl = 2'd2; end
      else begin e.pa = {e2[31:12], va[11:0]}; e.lvl = 2'd0; end
    end
    e.ackdly = ackdly;
    exp_q.push_back(e);
    rsp_lat = lat;
    n = done_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_root = root;
    @(negedge clk);
    chk(!req_ready, "R2 busy after accept", {31'b0, req_ready}, 32'h0);
    if (spam) begin req_vaddr = ~va; req_root = root + 32'h40; end  // R10
    else req_valid = 1'b0;
    wait (done_cnt == n + 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready, "R9 idle after ack", {31'b0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pt[32'h0001_0004] = 32'h0002_0001;
    pt[32'h0002_000C] = 32'h0ABC_D001;
    pt[32'h0001_0FFC] = 32'h0003_0FFF;
    pt[32'h0003_0FFC] = 32'hFFFF_F001;
    pt[32'h0001_000C] = 32'h1234_5FFE;
    pt[32'h0002_0018] = 32'h5555_5FFE;
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk(!res_valid, "R1 res_valid", {31'b0, res_valid}, 32'h0);
    chk(!mem_rd_valid, "R1 mem_rd_valid", {31'b0, mem_rd_valid}, 32'h0);
    rst_n = 1'b1;
    walk(32'h0040_3123, 32'h0001_0000, 1, 0, 0);  // R5
    walk(32'h0080_0000, 32'h0001_0000, 2, 2, 0);  // R6 absent entry
    walk(32'h00C0_0000, 32'h0001_0000, 3, 0, 0);  // R6 bit0 clear, other bits set
    walk(32'h0040_5000, 32'h0001_0000, 1, 1, 0);  // R7 absent entry
    walk(32'h0040_6ABC, 32'h0001_0000, 4, 3, 0);  // R7 bit0 clear
    walk(32'h0040_3FFF, 32'h0001_0003, 2, 0, 0);  // R3 root low bits ignored
    walk(32'hFFFF_FABC, 32'h0001_0000, 5, 4, 0);  // R4 top indices, entry bits ignored
    walk(32'h0040_3000, 32'h0001_0000, 6, 5, 1);  // R10 request held during walk
    walk(32'h0080_0123, 32'h0001_0000, 3, 2, 1);  // R10 with first-level fault
    walk(32'h0040_3456, 32'h0001_0000, 1, 0, 0);  // R8 back-to-back
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule